// File: doc/BRIEF.md
# Shared Forward/Inverse AES Byte Substitution

This block applies the AES byte substitution to a full 128-bit cipher state in one pass. It can run in either direction. A single direction input picks the forward substitution, used when encrypting, or its inverse, used when decrypting. All sixteen bytes are transformed in parallel and independently of one another.

Each byte lane holds one GF(2^8) multiplicative-inverse circuit, and both directions use it. The circuit works in a tower field:

- It first maps the byte into GF((2^4)^2) built over GF((2^2)^2).
- It then splits the byte into a high and a low nibble and inverts it with nibble-level arithmetic.
- Finally it maps the result back to GF(2^8).

The affine stages sit around this shared inverter, one on each side. For the forward direction, the affine transform follows the inverse. For the reverse direction, the inverse affine transform comes before it. The result is captured in one output register. The surrounding round logic sees a result one clock after it presents a valid state.

Top module: `bytesub_dual`

## Requirements
- R1: With `in_dec` = 0, every output byte equals the forward affine transform of the byte's multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1. Zero has inverse zero. The forward affine transform is b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63. Examples: 0x00 gives 0x63, 0x01 gives 0x7C, 0x53 gives 0xED.
- R2: With `in_dec` = 1, every output byte equals the multiplicative inverse of the inverse affine transform of the input byte. The inverse affine transform is rotl(b,1) ^ rotl(b,3) ^ rotl(b,6) ^ 0x05. Examples: 0x63 gives 0x00, 0xED gives 0x53.
- R3: Byte k of the state occupies bits [8k+7:8k] on both `in_state` and `out_state`. Each output byte depends only on the input byte in the same position.
- R4: Substituting a state forward and then feeding the result back with `in_dec` = 1 returns the original state.
- R5: `out_valid` is `in_valid` delayed by exactly one clock. The substituted state appears on `out_state` in that same cycle.
- R6: While `in_valid` is low, `out_state` keeps its last value, whatever `in_state` and `in_dec` do.
- R7: A clock edge with `rst_n` low clears `out_valid` and `out_state` to zero, even when `in_valid` is high.
- R8: The direction is taken from `in_dec` in the cycle `in_valid` is high. Two back-to-back states with opposite directions are each transformed in their own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input state is valid this cycle |
| in_dec | input | 1 | 1 = inverse substitution, 0 = forward substitution |
| in_state | input | 128 | Sixteen input bytes, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_state | output | 128 | Substituted state, registered |

## Verification
The hardest part to reach is full coverage of the shared inverter in every lane under both stage orders. A lane sees only the byte in its own position, so a naive sweep would exercise each lane on a fraction of the values. The stimulus therefore walks 256 vectors per direction and gives lane k the value v + 17k. Every lane then meets all 256 byte values in both directions, including zero and the inputs whose inverse-affine image is zero. Each result is compared against an inverse found by brute-force search with a shift-and-add multiplier. Back-to-back transfers that switch direction on each transfer, and round trips of forward results, then cover the mode switching at the input register.

// File: rtl/bytesub_pkg.sv
// Package: shared types and GF arithmetic for the byte substitution unit.
// Assumes tower GF(((2^2)^2)^2): GF(4) with x^2+x+1, GF(16) with z^2+z+PHI,
// GF(256) with y^2+y+LAMBDA. LAMBDA and the basis maps are derived by
// constant functions at elaboration, so no hand-entered matrix is needed.
package bytesub_pkg;

    typedef logic [7:0] byte_t;
    typedef logic [3:0] nib_t;
    typedef logic [1:0] duo_t;
    typedef logic [7:0][7:0] bitmat_t;  // entry i = image of input bit i

    localparam duo_t  PHI      = 2'b10;
    localparam byte_t AES_POLY = 8'h1B;  // x^8 + x^4 + x^3 + x + 1, low byte

    // GF(4) product, x^2 = x + 1
    function automatic duo_t gf4_mul(duo_t a, duo_t b);
        duo_t r;
        r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
        r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
        return r;
    endfunction

    // GF(4) square, which is also the inverse of a nonzero element
    function automatic duo_t gf4_sq(duo_t a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    // GF(16) product over GF(4), z^2 = z + PHI
    function automatic nib_t gf16_mul(nib_t a, nib_t b);
        duo_t hg, hk, lg, lk;
        hg = gf4_mul(a[3:2], b[3:2]);
        hk = gf4_mul(a[3:2], b[1:0]);
        lg = gf4_mul(a[1:0], b[3:2]);
        lk = gf4_mul(a[1:0], b[1:0]);
        return {hg ^ hk ^ lg, gf4_mul(hg, PHI) ^ lk};
    endfunction

    // GF(16) square
    function automatic nib_t gf16_sq(nib_t a);
        return gf16_mul(a, a);
    endfunction

    // GF(16) inverse through a GF(4) norm; zero maps to zero
    function automatic nib_t gf16_inv(nib_t a);
        duo_t h, l, d, di;
        h  = a[3:2];
        l  = a[1:0];
        d  = gf4_mul(gf4_sq(h), PHI) ^ gf4_mul(h, l) ^ gf4_sq(l);
        di = gf4_sq(d);
        return {gf4_mul(h, di), gf4_mul(h ^ l, di)};
    endfunction

    // Smallest LAMBDA making y^2+y+LAMBDA irreducible over GF(16)
    function automatic nib_t find_lambda();
        for (int c = 1; c < 16; c++) begin
            logic has_root;
            has_root = 1'b0;
            for (int y = 0; y < 16; y++) begin
                if ((gf16_sq(y[3:0]) ^ y[3:0]) == c[3:0]) has_root = 1'b1;
            end
            if (!has_root) return c[3:0];
        end
        return 4'h0;
    endfunction

    // Product in the tower GF(256), y^2 = y + lam
    function automatic byte_t tower_mul(byte_t a, byte_t b, nib_t lam);
        nib_t hg, hk, lg, lk;
        hg = gf16_mul(a[7:4], b[7:4]);
        hk = gf16_mul(a[7:4], b[3:0]);
        lg = gf16_mul(a[3:0], b[7:4]);
        lk = gf16_mul(a[3:0], b[3:0]);
        return {hg ^ hk ^ lg, gf16_mul(hg, lam) ^ lk};
    endfunction

    // Tower element that is a root of the AES field polynomial
    function automatic byte_t find_root(nib_t lam);
        logic [8:0] poly;
        poly = {1'b1, AES_POLY};
        for (int c = 2; c < 256; c++) begin
            byte_t pw, acc;
            pw  = 8'h01;
            acc = 8'h00;
            for (int i = 0; i < 9; i++) begin
                if (poly[i]) acc = acc ^ pw;
                pw = tower_mul(pw, c[7:0], lam);
            end
            if (acc == 8'h00) return c[7:0];
        end
        return 8'h00;
    endfunction

    // Linear map over GF(2): XOR of the columns selected by the set bits
    function automatic byte_t apply_mat(bitmat_t m, byte_t a);
        byte_t r;
        r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) r = r ^ m[i];
        end
        return r;
    endfunction

    // AES basis to tower basis: bit i goes to root^i
    function automatic bitmat_t to_tower_mat(nib_t lam);
        bitmat_t m;
        byte_t   beta, pw;
        beta = find_root(lam);
        pw   = 8'h01;
        for (int i = 0; i < 8; i++) begin
            m[i] = pw;
            pw   = tower_mul(pw, beta, lam);
        end
        return m;
    endfunction

    // Tower basis back to AES basis, found by searching the forward map
    function automatic bitmat_t from_tower_mat(bitmat_t fwd);
        bitmat_t m;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            for (int a = 0; a < 256; a++) begin
                if (apply_mat(fwd, a[7:0]) == byte_t'(1 << j)) m[j] = a[7:0];
            end
        end
        return m;
    endfunction

    // Rotate a byte left by n
    function automatic byte_t rotl8(byte_t b, int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

endpackage

// File: rtl/bytesub_affine.sv
// Module: one affine stage of the substitution, forward or inverse.
// INVERSE = 0 gives the forward transform, 1 the inverse transform.
// Purely combinational; assumes nothing about its input.
module bytesub_affine
    import bytesub_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);

    generate
        if (INVERSE) begin : g_inverse
            // inverse transform: three rotations plus constant 0x05
            always_comb begin
                dout = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05;
            end
        end else begin : g_forward
            // forward transform: identity, four rotations, constant 0x63
            always_comb begin
                dout = din ^ rotl8(din, 1) ^ rotl8(din, 2)
                     ^ rotl8(din, 3) ^ rotl8(din, 4) ^ 8'h63;
            end
        end
    endgenerate

endmodule

// File: rtl/bytesub_inv.sv
// Module: GF(2^8) multiplicative inverse computed in a tower field.
// The stages are: map into GF((2^4)^2), invert through a GF(16) norm, map back.
// Zero maps to zero. Combinational; the maps are elaboration constants.
module bytesub_inv
    import bytesub_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);

    localparam nib_t    LAMBDA     = find_lambda();
    localparam bitmat_t TO_TOWER   = to_tower_mat(LAMBDA);
    localparam bitmat_t FROM_TOWER = from_tower_mat(TO_TOWER);

    byte_t t_in;
    byte_t t_out;
    nib_t  hi, lo;
    nib_t  norm;
    nib_t  norm_inv;

    // stage 1: change of basis into the tower field
    always_comb begin
        t_in = apply_mat(TO_TOWER, din);
        hi   = t_in[7:4];
        lo   = t_in[3:0];
    end

    // stage 2a: norm hi^2*LAMBDA + hi*lo + lo^2 and its GF(16) inverse
    always_comb begin
        norm     = gf16_mul(gf16_sq(hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
        norm_inv = gf16_inv(norm);
    end

    // stage 2b: inverse halves, hi*N^-1 and (hi+lo)*N^-1
    always_comb begin
        t_out = {gf16_mul(hi, norm_inv), gf16_mul(hi ^ lo, norm_inv)};
    end

    // stage 3: change of basis back to the AES field
    always_comb begin
        dout = apply_mat(FROM_TOWER, t_out);
    end

endmodule

// File: rtl/bytesub_lane.sv
// Module: one byte lane. The shared inverter has the inverse affine stage
// in front of it for decryption and the forward affine stage behind it
// for encryption. Combinational.
module bytesub_lane (
    input  logic       dec,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    logic [7:0] pre_aff;   // inverse affine of the input
    logic [7:0] inv_in;
    logic [7:0] inv_out;
    logic [7:0] post_aff;  // forward affine of the inverse

    bytesub_affine #(.INVERSE(1'b1)) u_pre (
        .din  (din),
        .dout (pre_aff)
    );

    // route input: inverse affine comes first only when decrypting
    always_comb begin
        inv_in = dec ? pre_aff : din;
    end

    bytesub_inv u_inv (
        .din  (inv_in),
        .dout (inv_out)
    );

    bytesub_affine #(.INVERSE(1'b0)) u_post (
        .din  (inv_out),
        .dout (post_aff)
    );

    // route output: forward affine comes last only when encrypting
    always_comb begin
        dout = dec ? inv_out : post_aff;
    end

endmodule

// File: rtl/bytesub_dual.sv
// Module: top of the shared forward/inverse byte substitution unit.
// NUM_BYTES identical lanes work in parallel on the state. One output
// register stage: out_valid is in_valid delayed by one clock, and the data
// register loads only on valid. Synchronous active-low reset.
module bytesub_dual #(
    parameter int NUM_BYTES = 16,
    localparam int STATE_W  = 8 * NUM_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_dec,
    input  logic [STATE_W-1:0] in_state,
    output logic               out_valid,
    output logic [STATE_W-1:0] out_state
);

    logic [STATE_W-1:0] sub_state;

    generate
        for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
            bytesub_lane u_lane (
                .dec  (in_dec),
                .din  (in_state[8*k +: 8]),
                .dout (sub_state[8*k +: 8])
            );
        end
    endgenerate

    // output register: capture substituted state on valid, track strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_state <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_state <= sub_state;
        end
    end

endmodule

// File: rtl/bytesub_dual_chk.sv
// Checker: timing and known-value properties of bytesub_dual, bound below.
// Assumes synchronous active-low reset; all properties are off in reset.
module bytesub_dual_chk #(
    parameter int STATE_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_dec,
    input logic [STATE_W-1:0] in_state,
    input logic               out_valid,
    input logic [STATE_W-1:0] out_state
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R5
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_state));  // R6
    AST_ENC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dec && in_state[7:0] == 8'h00) |=> out_state[7:0] == 8'h63);  // R1
    AST_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dec && in_state[7:0] == 8'h63) |=> out_state[7:0] == 8'h00);  // R2

endmodule

bind bytesub_dual bytesub_dual_chk #(.STATE_W(STATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dec    (in_dec),
    .in_state  (in_state),
    .out_valid (out_valid),
    .out_state (out_state)
);

// File: tb/bytesub_dual_bench.sv
`timescale 1ns/1ps
module bytesub_dual_bench;

    localparam int NB = 16;
    localparam int W  = 8 * NB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_dec = 1'b0;
    logic [W-1:0] in_state = '0;
    logic         out_valid;
    logic [W-1:0] out_state;

    int checks = 0;
    int errors = 0;

    bytesub_dual u_bytesub_dual (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dec    (in_dec),
        .in_state  (in_state),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    always #4 clk = ~clk;  // 125 MHz

    // shift-and-add product modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] rmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
        end
        return p;
    endfunction

    // brute-force inverse; zero maps to zero
    function automatic logic [7:0] rinv(logic [7:0] a);
        for (int c = 1; c < 256; c++) begin
            if (rmul(a, c[7:0]) == 8'h01) return c[7:0];
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] rl(logic [7:0] b, int n);
        return 8'((b << n) | (b >> (8 - n)));
    endfunction

    function automatic logic [7:0] ref_enc(logic [7:0] b);
        logic [7:0] m = rinv(b);
        return m ^ rl(m, 1) ^ rl(m, 2) ^ rl(m, 3) ^ rl(m, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] ref_dec(logic [7:0] b);
        return rinv(rl(b, 1) ^ rl(b, 3) ^ rl(b, 6) ^ 8'h05);
    endfunction

    function automatic logic [W-1:0] ref_state(logic dec, logic [W-1:0] s);
        logic [W-1:0] r;
        for (int k = 0; k < NB; k++) begin
            r[8*k +: 8] = dec ? ref_dec(s[8*k +: 8]) : ref_enc(s[8*k +: 8]);
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one transfer: drive at negedge, read result one clock later
    task automatic xfer(logic dec, logic [W-1:0] s, output logic [W-1:0] got);
        @(negedge clk);
        in_valid = 1'b1;
        in_dec   = dec;
        in_state = s;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 valid after one clock", {127'd0, out_valid}, {127'd0, 1'b1});
        got = out_state;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] got, vec, held, v2;

        repeat (3) @(negedge clk);
        check("R7 reset valid", {127'd0, out_valid}, '0);
        check("R7 reset state", out_state, '0);
        rst_n = 1'b1;

        // known values in lane 0, lane 1, lane 2
        xfer(1'b0, {104'd0, 8'h53, 8'h01, 8'h00}, got);
        check("R1 known forward values", got[23:0], {ref_enc(8'h53), ref_enc(8'h01), 8'h63});
        check("R1 0x53 to 0xED", {120'd0, got[23:16]}, {120'd0, 8'hED});
        xfer(1'b1, {112'd0, 8'hED, 8'h63}, got);
        check("R2 known inverse values", {112'd0, got[15:0]}, {112'd0, 8'h53, 8'h00});

        // exhaustive sweep: lane k sees v + 17k, all 256 values per lane
        for (int mode = 0; mode < 2; mode++) begin
            for (int v = 0; v < 256; v++) begin
                for (int k = 0; k < NB; k++) vec[8*k +: 8] = 8'(v + 17 * k);
                xfer(mode[0], vec, got);
                check(mode[0] ? "R2 inverse sweep, R3 lanes" : "R1 forward sweep, R3 lanes",
                      got, ref_state(mode[0], vec));
            end
        end

        // round trip on varied states
        for (int v = 0; v < 32; v++) begin
            for (int k = 0; k < NB; k++) vec[8*k +: 8] = 8'(v * 29 + k * 53 + 7);
            xfer(1'b0, vec, got);
            xfer(1'b1, got, v2);
            check("R4 round trip", v2, vec);
        end

        // back-to-back transfers with alternating direction
        for (int k = 0; k < NB; k++) vec[8*k +: 8] = 8'(k * 11 + 3);
        @(negedge clk);
        in_valid = 1'b1; in_dec = 1'b0; in_state = vec;
        @(negedge clk);
        check("R8 first of pair forward", out_state, ref_state(1'b0, vec));
        in_dec = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second of pair inverse", out_state, ref_state(1'b1, vec));
        check("R5 valid in pair", {127'd0, out_valid}, {127'd0, 1'b1});

        // idle: inputs change, output must hold and valid drop
        held = out_state;
        in_dec = 1'b0;
        in_state = ~vec;
        @(negedge clk);
        check("R5 valid low when idle", {127'd0, out_valid}, '0);
        in_dec = 1'b1;
        in_state = {W{1'b1}};
        repeat (3) @(negedge clk);
        check("R6 hold when idle", out_state, held);

        // reset while valid is high clears the outputs
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset clears valid", {127'd0, out_valid}, '0);
        check("R7 reset clears state", out_state, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule